// File: doc/BRIEF.md
# AXI Read Data Padding Remover

This block sits on the read-data return path of a narrow-to-wide AXI read upconverter. The wide side returns full-width beats. When the narrow request was not aligned to the wide bus, some of the narrow lanes in the first and last wide beats hold words that were never requested. A burst-information FIFO supplies one entry per burst, in the order the bursts were issued. Each entry gives the lane of the first requested word and the narrow burst length. The block unpacks each wide beat into narrow beats, forwards only the requested words, and puts the narrow last flag on the final requested word.

The ID and response of each wide beat pass through to every narrow beat taken from it. Each burst ends when the wide beat carrying the wide last flag is consumed, which also pops the information entry. Because the FIFO is read in issue order, the block depends on read data coming back in that same order.

Top module: `padrm_read_unpad`

## Requirements
- R1: Narrow lane i of a wide beat is `r_data[i*NARROW_W +: NARROW_W]`. Lanes are presented from the lowest to the highest index, and a burst continues from lane 0 of the next wide beat.
- R2: The first narrow beat of a burst is lane `info_start` of the first wide beat. Lanes below it in that beat are never presented.
- R3: Exactly `info_len + 1` narrow beats are presented per burst. Lanes after the final requested word are never presented, and neither are whole wide beats that follow it up to the wide last beat.
- R4: `l_last` is high on narrow beat number `info_len + 1` of the burst and on no other beat, whatever lane or wide beat the wide last flag falls on.
- R5: `l_resp` and `l_id` equal `r_resp` and `r_id` of the wide beat the narrow beat is taken from.
- R6: `r_ready` is high only in two cases: in the cycle the top lane or the final requested lane of the current wide beat is accepted on the left side, or for a wide beat that holds only words after the final requested one.
- R7: `info_ready` is high exactly in the cycle the wide beat carrying `r_last` is consumed.
- R8: While `l_valid` is high and `l_ready` is low, `l_data`, `l_last` and `l_resp` hold, `r_ready` stays low, and no narrow beat is dropped or repeated.
- R9: With `info_valid` or `r_valid` low, `l_valid` and `r_ready` are low.
- R10: A synchronous active-high `rst` clears the lane pointer and the beat counter, so the next burst starts at its own `info_start` lane with a fresh count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| info_valid | input | 1 | Burst-information entry available |
| info_ready | output | 1 | Burst-information entry consumed |
| info_start | input | LANE_W | Lane of the first requested word in the first wide beat |
| info_len | input | LEN_W | Narrow burst length minus one |
| r_valid | input | 1 | Wide read beat valid |
| r_ready | output | 1 | Wide read beat consumed |
| r_data | input | NARROW_W*LANES | Wide read data |
| r_id | input | ID_W | Wide read ID |
| r_resp | input | 2 | Wide read response |
| r_last | input | 1 | Last wide beat of the burst |
| l_valid | output | 1 | Narrow read beat valid |
| l_ready | input | 1 | Narrow read beat accepted |
| l_data | output | NARROW_W | Narrow read data |
| l_id | output | ID_W | Narrow read ID |
| l_resp | output | 2 | Narrow read response |
| l_last | output | 1 | Final requested narrow beat of the burst |

## Verification
Every padding word carries its own lane-and-beat code. If the start lane were ignored, a leading padding word would reach the left side. If the count stopped too late, a trailing padding word would appear, or a padding-only wide beat would never be drained. The bench covers bursts that start on the top lane, bursts that end on the top lane, single-word bursts, bursts that cross several wide beats, and bursts with extra padding-only wide beats. In each of these a misplaced last flag, or a wide beat popped one lane early or late, shows up as a data or ready mismatch. Left-side stalls and right-side bubbles catch repeated or lost words. A reset in the middle of a burst followed by a new burst shows whether the lane pointer and the count were really cleared.

// File: rtl/padrm_pkg.sv
package padrm_pkg;

  typedef enum logic [1:0] {
    TRK_FRESH = 2'd0,
    TRK_MID   = 2'd1,
    TRK_DRAIN = 2'd2
  } trk_state_e;

  function automatic bit lane_is_top(int unsigned lane, int unsigned lanes);
    return lane == lanes - 1;
  endfunction

  function automatic int unsigned next_lane(int unsigned lane, int unsigned lanes);
    return (lane + 1 >= lanes) ? 0 : lane + 1;
  endfunction

  function automatic bit beat_is_final(int unsigned sent, int unsigned len_m1);
    return sent == len_m1;
  endfunction

endpackage

// File: rtl/padrm_lane_select.sv
module padrm_lane_select #(
  parameter int NARROW_W = 16,
  parameter int LANES    = 4,
  parameter int LANE_W   = 2
) (
  input  logic [NARROW_W*LANES-1:0] wide,
  input  logic [LANE_W-1:0]         sel,
  output logic [NARROW_W-1:0]       narrow
);

  logic [NARROW_W-1:0] slice [LANES];

  for (genvar g = 0; g < LANES; g++) begin : g_slice
    assign slice[g] = wide[g*NARROW_W +: NARROW_W];
  end

  assign narrow = slice[sel];

endmodule

// File: rtl/padrm_burst_track.sv
module padrm_burst_track
  import padrm_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int LANE_W = 2,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [LANE_W-1:0] start_lane,
  input  logic [LEN_W-1:0]  len_m1,
  input  logic              lane_fire,
  input  logic              burst_close,
  output logic [LANE_W-1:0] cur_lane,
  output logic              final_beat,
  output logic              draining
);

  trk_state_e        state_q;
  logic [LANE_W-1:0] lane_q;
  logic [LEN_W-1:0]  sent_q;

  assign cur_lane   = (state_q == TRK_FRESH) ? start_lane : lane_q;
  assign final_beat = beat_is_final(int'(sent_q), int'(len_m1));
  assign draining   = (state_q == TRK_DRAIN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= TRK_FRESH;
      lane_q  <= '0;
      sent_q  <= '0;
    end else if (burst_close) begin
      state_q <= TRK_FRESH;
      lane_q  <= '0;
      sent_q  <= '0;
    end else if (lane_fire) begin
      sent_q  <= sent_q + LEN_W'(1);
      lane_q  <= LANE_W'(next_lane(int'(cur_lane), LANES));
      state_q <= final_beat ? TRK_DRAIN : TRK_MID;
    end
  end

endmodule

// File: rtl/padrm_read_unpad.sv
module padrm_read_unpad
  import padrm_pkg::*;
#(
  parameter int NARROW_W = 16,
  parameter int LANES    = 4,
  parameter int ID_W     = 4,
  parameter int LEN_W    = 8,
  localparam int WIDE_W  = NARROW_W * LANES,
  localparam int LANE_W  = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              info_valid,
  output logic              info_ready,
  input  logic [LANE_W-1:0] info_start,
  input  logic [LEN_W-1:0]  info_len,
  input  logic              r_valid,
  output logic              r_ready,
  input  logic [WIDE_W-1:0] r_data,
  input  logic [ID_W-1:0]   r_id,
  input  logic [1:0]        r_resp,
  input  logic              r_last,
  output logic              l_valid,
  input  logic              l_ready,
  output logic [NARROW_W-1:0] l_data,
  output logic [ID_W-1:0]   l_id,
  output logic [1:0]        l_resp,
  output logic              l_last
);

  // Named internal events, observed by the bound checker.
  logic              lane_fire;
  logic              wide_pop;
  logic              burst_close;
  logic              lane_top;
  logic [LANE_W-1:0] cur_lane;
  logic              final_beat;
  logic              draining;
  logic              both_valid;

  padrm_burst_track #(
    .LANES  (LANES),
    .LANE_W (LANE_W),
    .LEN_W  (LEN_W)
  ) u_track (
    .clk         (clk),
    .rst         (rst),
    .start_lane  (info_start),
    .len_m1      (info_len),
    .lane_fire   (lane_fire),
    .burst_close (burst_close),
    .cur_lane    (cur_lane),
    .final_beat  (final_beat),
    .draining    (draining)
  );

  padrm_lane_select #(
    .NARROW_W (NARROW_W),
    .LANES    (LANES),
    .LANE_W   (LANE_W)
  ) u_select (
    .wide   (r_data),
    .sel    (cur_lane),
    .narrow (l_data)
  );

  assign both_valid  = info_valid & r_valid;
  assign lane_top    = lane_is_top(int'(cur_lane), LANES);
  assign l_valid     = both_valid & ~draining;
  assign lane_fire   = l_valid & l_ready;
  assign wide_pop    = (lane_fire & (lane_top | final_beat)) | (both_valid & draining);
  assign burst_close = wide_pop & r_last;

  assign r_ready    = wide_pop;
  assign info_ready = burst_close;
  assign l_last     = final_beat & ~draining;
  assign l_id       = r_id;
  assign l_resp     = r_resp;

endmodule

// File: rtl/padrm_checker.sv
module padrm_checker #(
  parameter int NARROW_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                info_valid,
  input logic                info_ready,
  input logic                r_valid,
  input logic                r_ready,
  input logic                r_last,
  input logic                l_valid,
  input logic                l_ready,
  input logic [NARROW_W-1:0] l_data,
  input logic [1:0]          l_resp,
  input logic                l_last,
  input logic                lane_fire,
  input logic                burst_close
);

  assert_gate_R9: assert property (@(posedge clk) disable iff (rst)
    (!info_valid || !r_valid) |-> (!l_valid && !r_ready));

  assert_stall_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (l_valid && !l_ready) |=> (l_valid && $stable(l_data) && $stable(l_last) && $stable(l_resp)));

  assert_stall_nopop_R8: assert property (@(posedge clk) disable iff (rst)
    (l_valid && !l_ready) |-> !r_ready);

  assert_info_pop_R7: assert property (@(posedge clk) disable iff (rst)
    info_ready |-> (r_valid && r_ready && r_last));

  assert_after_last_R4: assert property (@(posedge clk) disable iff (rst)
    (lane_fire && l_last && !burst_close) |=> !l_valid);

  assert_pop_accept_R6: assert property (@(posedge clk) disable iff (rst)
    (r_ready && l_valid) |-> l_ready);

endmodule

bind padrm_read_unpad padrm_checker #(.NARROW_W(NARROW_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .info_valid  (info_valid),
  .info_ready  (info_ready),
  .r_valid     (r_valid),
  .r_ready     (r_ready),
  .r_last      (r_last),
  .l_valid     (l_valid),
  .l_ready     (l_ready),
  .l_data      (l_data),
  .l_resp      (l_resp),
  .l_last      (l_last),
  .lane_fire   (lane_fire),
  .burst_close (burst_close)
);

// File: tb/tb_padrm_read_unpad.sv
module tb_padrm_read_unpad;

  localparam int NW    = 16;
  localparam int LANES = 4;
  localparam int WW    = NW * LANES;
  localparam int IDW   = 4;
  localparam int LENW  = 8;
  localparam int NVEC  = 10;

  // columns: start lane, len-1, extra pad beats, stall, bubble, resp, id
  localparam int VEC [NVEC][7] = '{
    '{0,  3, 0, 0, 0, 0, 1},
    '{1,  0, 0, 0, 0, 1, 2},
    '{3,  0, 0, 1, 0, 2, 3},
    '{2,  5, 0, 0, 0, 3, 4},
    '{3,  9, 0, 1, 1, 0, 5},
    '{1,  6, 0, 1, 0, 2, 6},
    '{0,  0, 1, 0, 0, 1, 7},
    '{2,  4, 2, 1, 1, 3, 8},
    '{0, 15, 0, 0, 1, 0, 9},
    '{3,  1, 0, 1, 0, 2, 10}
  };

  logic            clk = 0;
  logic            rst = 1;
  logic            info_valid = 0;
  logic            info_ready;
  logic [1:0]      info_start = '0;
  logic [LENW-1:0] info_len = '0;
  logic            r_valid = 0;
  logic            r_ready;
  logic [WW-1:0]   r_data = '0;
  logic [IDW-1:0]  r_id = '0;
  logic [1:0]      r_resp = '0;
  logic            r_last = 0;
  logic            l_valid;
  logic            l_ready = 0;
  logic [NW-1:0]   l_data;
  logic [IDW-1:0]  l_id;
  logic [1:0]      l_resp;
  logic            l_last;

  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  padrm_read_unpad #(
    .NARROW_W (NW),
    .LANES    (LANES),
    .ID_W     (IDW),
    .LEN_W    (LENW)
  ) dut (
    .clk        (clk),
    .rst        (rst),
    .info_valid (info_valid),
    .info_ready (info_ready),
    .info_start (info_start),
    .info_len   (info_len),
    .r_valid    (r_valid),
    .r_ready    (r_ready),
    .r_data     (r_data),
    .r_id       (r_id),
    .r_resp     (r_resp),
    .r_last     (r_last),
    .l_valid    (l_valid),
    .l_ready    (l_ready),
    .l_data     (l_data),
    .l_id       (l_id),
    .l_resp     (l_resp),
    .l_last     (l_last)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h at %0t", req, what, act, exp, $time);
    end
  endtask

  function automatic logic [NW-1:0] word_code(int b, int idx);
    return NW'(((b & 8'hff) << 8) | (idx & 8'hff));
  endfunction

  function automatic logic [WW-1:0] beat_code(int b, int k);
    logic [WW-1:0] w = '0;
    for (int ln = 0; ln < LANES; ln++) w[ln*NW +: NW] = word_code(b, k*LANES + ln);
    return w;
  endfunction

  task automatic run_burst(input int b, input int start, input int len, input int extra,
                           input int stall, input int gap, input int resp, input int id);
    int  nbeats = (start + len) / LANES + 1 + extra;
    int  k = 0;
    int  got = 0;
    int  cyc = 0;
    bit  done, exp_lv, fire, exp_pop;
    @(negedge clk);
    info_valid = 1; info_start = 2'(start); info_len = LENW'(len);
    r_id = IDW'(id); r_resp = 2'(resp);
    r_data = beat_code(b, 0); r_last = (nbeats == 1); r_valid = 1;
    while (k < nbeats) begin
      l_ready = stall ? (cyc % 3 != 0) : 1'b1;
      #1;
      done   = got > len;
      exp_lv = r_valid && !done;
      check(l_valid == exp_lv, "R3/R9", "l_valid", l_valid, exp_lv);
      if (exp_lv && l_valid) begin
        check(l_data == word_code(b, start + got), "R1/R2/R8", "l_data", l_data, word_code(b, start + got));
        check(l_last == (got == len), "R4", "l_last", l_last, (got == len));
        check(l_resp == 2'(resp), "R5", "l_resp", l_resp, resp);
        check(l_id == IDW'(id), "R5", "l_id", l_id, id);
      end
      fire    = exp_lv && l_ready;
      exp_pop = done ? r_valid : (fire && (((start + got) % LANES == LANES - 1) || got == len));
      check(r_ready == exp_pop, "R6/R8", "r_ready", r_ready, exp_pop);
      check(info_ready == (exp_pop && k == nbeats - 1), "R7", "info_ready", info_ready,
            (exp_pop && k == nbeats - 1));
      if (fire) got++;
      @(posedge clk);
      cyc++;
      if (cyc > 400) begin
        check(0, "R3", "burst watchdog", cyc, 400);
        break;
      end
      @(negedge clk);
      if (exp_pop) begin
        k++;
        if (k < nbeats) begin
          r_data  = beat_code(b, k);
          r_last  = (k == nbeats - 1);
          r_valid = !(gap != 0 && k % 2 == 1);
        end
      end else if (!r_valid) begin
        r_valid = 1;
      end
    end
    check(got == len + 1, "R3", "narrow beat count", got, len + 1);
    info_valid = 0; r_valid = 0; r_last = 0; l_ready = 0;
  endtask

  initial begin
    #(20 * 150000);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(l_valid == 0 && r_ready == 0 && info_ready == 0, "R10", "idle in reset",
          {l_valid, r_ready, info_ready}, 0);
    rst = 0;

    // table walk
    for (int v = 0; v < NVEC; v++)
      run_burst(v + 1, VEC[v][0], VEC[v][1], VEC[v][2], VEC[v][3], VEC[v][4], VEC[v][5], VEC[v][6]);

    // R9: gating on either valid low
    @(negedge clk);
    info_valid = 0; r_valid = 1; l_ready = 1; r_data = beat_code(40, 0);
    #1;
    check(l_valid == 0 && r_ready == 0, "R9", "no info entry", {l_valid, r_ready}, 0);
    @(negedge clk);
    info_valid = 1; r_valid = 0; info_start = 2'd0; info_len = 8'd3;
    #1;
    check(l_valid == 0 && r_ready == 0, "R9", "no wide beat", {l_valid, r_ready}, 0);
    @(negedge clk);
    info_valid = 0; l_ready = 0;

    // R10: reset in the middle of a burst, then a fresh burst
    @(negedge clk);
    info_valid = 1; info_start = 2'd2; info_len = 8'd5;
    r_valid = 1; r_data = beat_code(50, 0); r_last = 0; r_id = '0; r_resp = '0; l_ready = 1;
    @(posedge clk);
    @(negedge clk);
    info_valid = 0; r_valid = 0; l_ready = 0; rst = 1;
    @(posedge clk);
    @(negedge clk);
    rst = 0;
    #1;
    check(l_valid == 0 && r_ready == 0, "R10", "idle after reset", {l_valid, r_ready}, 0);
    run_burst(60, 1, 2, 0, 0, 0, 1, 11);
    run_burst(61, 3, 4, 1, 1, 1, 2, 12);

    repeat (2) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule